// File: doc/BRIEF.md
# Output Port Round-Robin Arbiter

This block sits at one output port of a mesh router and chooses which of several input switch controllers may send a packet through that port. Each input raises a port request. The arbiter picks one of them, raises that input's grant as its acknowledge, and offers the packet downstream through `fwd_valid`/`fwd_src`. It holds that grant until the next router's buffer returns `fwd_ack`. The default has two inputs: input 0 is the local port and input 1 is one neighbour. The `N_IN` parameter raises the count.

Priority is not changed inside the arbiter. A separate round-robin scheduler holds it. When a grant completes, the scheduler records the input that comes after the served one. A switch controller commits that pending value by pulsing a scheduler request before it asks for the port. The scheduler then walks through four transit states, coded 00, 11, 01 and 10, and at the end it loads the pending value as the new priority. New grants wait while the walk is in progress.

Top module: `output_port_arbiter`

## Requirements
- R1: While reset is low and after it is released, `port_gnt` is all zero, `fwd_valid` is 0, `prio` is 0, `sched_busy` is 0 and `sched_code` is 00.
- R2: If exactly one input requests while the arbiter is idle and the scheduler is not busy, that input is granted one cycle later, whatever `prio` holds.
- R3: If several inputs request under the same conditions, the grant goes to the first requesting input found by counting upward from `prio`, wrapping at N_IN. With two inputs, `prio`=0 favours input 0 (local) and `prio`=1 favours input 1.
- R4: At most one bit of `port_gnt` is high. While `fwd_valid` is 1, `fwd_src` holds the index of the granted input.
- R5: A grant and `fwd_valid` stay constant until a cycle in which `fwd_ack` is 1. In the cycle after that, both are low. Dropping a port request does not remove a grant.
- R6: A scheduler request seen while the scheduler is idle makes `sched_busy` high for exactly four cycles. During those cycles `sched_code` shows 00, 11, 01, 10 in that order. `sched_code` is 00 whenever `sched_busy` is low.
- R7: When the walk ends, `prio` takes the pending value. The pending value is the index after the input whose grant last completed (wrapping to 0), and it is 0 if no grant has completed since reset. A completion on that same edge does not affect the value loaded.
- R8: No new grant starts on an edge where `sched_busy` was high. A scheduler request that arrives during a walk is ignored and does not lengthen the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_req | input | N_IN | Per-input request to commit the next round-robin priority |
| port_req | input | N_IN | Per-input request for the output port |
| fwd_ack | input | 1 | Downstream buffer accepted the forwarded packet |
| port_gnt | output | N_IN | One-hot acknowledge to the granted input |
| fwd_valid | output | 1 | A packet is being offered downstream |
| fwd_src | output | max(1,clog2(N_IN)) | Index of the input being served |
| prio | output | max(1,clog2(N_IN)) | Current round-robin priority |
| sched_busy | output | 1 | Scheduler walk in progress |
| sched_code | output | 2 | Transit state code of the scheduler |

## Verification
A grant, a release and each step of the scheduler walk appear one clock after the edge that samples their cause. A new priority appears on the fifth edge after the scheduler request. The bench drives its inputs at falling edges and keeps a cycle model that it advances at each rising edge from the values held before that edge. It compares every output at the following falling edge. The directed cases check the same latencies as explicit constants: the walk codes, the absence of grants during the walk, and the grant on the edge after the walk ends.

// File: rtl/output_port_arbiter.sv
module output_port_arbiter #(
  parameter int N_IN = 2,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] sched_req,
  input  logic [N_IN-1:0] port_req,
  input  logic            fwd_ack,
  output logic [N_IN-1:0] port_gnt,
  output logic            fwd_valid,
  output logic [IW-1:0]   fwd_src,
  output logic [IW-1:0]   prio,
  output logic            sched_busy,
  output logic [1:0]      sched_code
);

  logic [1:0]    phase;
  logic [IW-1:0] pend;
  logic          serving;
  logic [IW-1:0] src;
  logic [IW-1:0] win;
  logic          found;
  logic [IW-1:0] after_src;

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N_IN; k++) begin
      int idx;
      idx = (int'(prio) + k) % N_IN;
      if (!found && port_req[idx]) begin
        win   = IW'(idx);
        found = 1'b1;
      end
    end
  end

  assign after_src = (src == IW'(N_IN - 1)) ? '0 : src + 1'b1;

  always_comb begin
    case (phase)
      2'd0:    sched_code = 2'b00;
      2'd1:    sched_code = 2'b11;
      2'd2:    sched_code = 2'b01;
      default: sched_code = 2'b10;
    endcase
    if (!sched_busy) sched_code = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sched_busy <= 1'b0;
      phase      <= 2'd0;
      prio       <= '0;
    end else if (!sched_busy) begin
      if (|sched_req) begin
        sched_busy <= 1'b1;
        phase      <= 2'd0;
      end
    end else if (phase == 2'd3) begin
      sched_busy <= 1'b0;
      phase      <= 2'd0;
      prio       <= pend;
    end else begin
      phase <= phase + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serving <= 1'b0;
      src     <= '0;
      pend    <= '0;
    end else if (!serving) begin
      if (!sched_busy && found) begin
        serving <= 1'b1;
        src     <= win;
      end
    end else if (fwd_ack) begin
      serving <= 1'b0;
      pend    <= after_src;
    end
  end

  assign fwd_valid = serving;
  assign fwd_src   = src;

  for (genvar g = 0; g < N_IN; g++) begin : g_gnt
    assign port_gnt[g] = serving && (src == IW'(g));
  end

endmodule

// File: rtl/output_port_arbiter_chk.sv
module output_port_arbiter_chk #(
  parameter int N_IN = 2,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_IN-1:0] sched_req,
  input logic [N_IN-1:0] port_req,
  input logic            fwd_ack,
  input logic [N_IN-1:0] port_gnt,
  input logic            fwd_valid,
  input logic [IW-1:0]   fwd_src,
  input logic [IW-1:0]   prio,
  input logic            sched_busy,
  input logic [1:0]      sched_code
);

  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_gnt));

  a_r4_src_granted: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> port_gnt[fwd_src]);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ack |=> fwd_valid && $stable(fwd_src) && $stable(port_gnt));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && fwd_ack |=> !fwd_valid && (port_gnt == '0));

  a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_valid && !sched_busy && ($countones(port_req) == 1) |=> port_gnt == $past(port_req));

  a_r6_step1: assert property (@(posedge clk) disable iff (!rst_n)
    sched_busy && sched_code == 2'b00 |=> sched_busy && sched_code == 2'b11);

  a_r6_step2: assert property (@(posedge clk) disable iff (!rst_n)
    sched_busy && sched_code == 2'b11 |=> sched_busy && sched_code == 2'b01);

  a_r6_step3: assert property (@(posedge clk) disable iff (!rst_n)
    sched_busy && sched_code == 2'b01 |=> sched_busy && sched_code == 2'b10);

  a_r6_end: assert property (@(posedge clk) disable iff (!rst_n)
    sched_busy && sched_code == 2'b10 |=> !sched_busy);

  a_r6_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_busy |-> sched_code == 2'b00);

  a_r8_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_valid && sched_busy |=> !fwd_valid);

  a_r7_prio_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_busy |=> $stable(prio));

endmodule

bind output_port_arbiter output_port_arbiter_chk #(.N_IN(N_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sched_req(sched_req), .port_req(port_req),
  .fwd_ack(fwd_ack), .port_gnt(port_gnt), .fwd_valid(fwd_valid),
  .fwd_src(fwd_src), .prio(prio), .sched_busy(sched_busy),
  .sched_code(sched_code));

// File: tb/output_port_arbiter_bench.sv
`timescale 1ns/1ps
module output_port_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sched_req = '0;
  logic [1:0] port_req = '0;
  logic       fwd_ack = 1'b0;
  logic [1:0] port_gnt;
  logic       fwd_valid;
  logic [0:0] fwd_src;
  logic [0:0] prio;
  logic       sched_busy;
  logic [1:0] sched_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic       m_srv, m_busy;
  logic [0:0] m_src, m_prio, m_pend;
  logic [1:0] m_phase;

  always #5 clk = ~clk;

  output_port_arbiter u_output_port_arbiter (
    .clk(clk), .rst_n(rst_n), .sched_req(sched_req), .port_req(port_req),
    .fwd_ack(fwd_ack), .port_gnt(port_gnt), .fwd_valid(fwd_valid),
    .fwd_src(fwd_src), .prio(prio), .sched_busy(sched_busy),
    .sched_code(sched_code));

  function automatic logic [0:0] f_winner(input logic [1:0] req, input logic [0:0] p);
    if (req[p]) return p;
    return ~p;
  endfunction

  function automatic logic [1:0] f_code(input logic busy, input logic [1:0] ph);
    if (!busy) return 2'b00;
    case (ph)
      2'd0: return 2'b00;
      2'd1: return 2'b11;
      2'd2: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_model();
    chk("R5", "fwd_valid", int'(fwd_valid), int'(m_srv));
    chk("R3", "port_gnt", int'(port_gnt), m_srv ? (1 << m_src) : 0);
    if (m_srv) chk("R4", "fwd_src", int'(fwd_src), int'(m_src));
    chk("R8", "sched_busy", int'(sched_busy), int'(m_busy));
    chk("R6", "sched_code", int'(sched_code), int'(f_code(m_busy, m_phase)));
    chk("R7", "prio", int'(prio), int'(m_prio));
  endtask

  task automatic step(input logic [1:0] sr, input logic [1:0] pr, input logic ak);
    logic nb, ns;
    logic [1:0] nph;
    logic [0:0] np, nsrc, npend;
    sched_req = sr; port_req = pr; fwd_ack = ak;
    @(posedge clk);
    nb = m_busy; nph = m_phase; np = m_prio; ns = m_srv; nsrc = m_src; npend = m_pend;
    if (!m_busy) begin
      if (|sr) begin nb = 1'b1; nph = 2'd0; end
    end else if (m_phase == 2'd3) begin
      nb = 1'b0; nph = 2'd0; np = m_pend;
    end else nph = m_phase + 2'd1;
    if (!m_srv) begin
      if (!m_busy && |pr) begin ns = 1'b1; nsrc = f_winner(pr, m_prio); end
    end else if (ak) begin
      ns = 1'b0; npend = ~m_src;
    end
    m_busy = nb; m_phase = nph; m_prio = np; m_srv = ns; m_src = nsrc; m_pend = npend;
    @(negedge clk);
    check_model();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_srv = 0; m_busy = 0; m_src = 0; m_prio = 0; m_pend = 0; m_phase = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "port_gnt", int'(port_gnt), 0);
    chk("R1", "fwd_valid", int'(fwd_valid), 0);
    chk("R1", "prio", int'(prio), 0);
    chk("R1", "sched_busy", int'(sched_busy), 0);
    chk("R1", "sched_code", int'(sched_code), 0);
    rst_n = 1'b1;
    step(2'b00, 2'b00, 1'b0);
    chk("R1", "port_gnt after release", int'(port_gnt), 0);

    // R2: only input 1 requests at prio 0
    step(2'b00, 2'b10, 1'b0);
    chk("R2", "single grant", int'(port_gnt), 2);
    step(2'b00, 2'b00, 1'b1);
    chk("R5", "released", int'(fwd_valid), 0);

    // R3: both at prio 0 go to input 0; R5 hold without ack
    step(2'b00, 2'b11, 1'b0);
    chk("R3", "prio0 winner", int'(port_gnt), 1);
    for (int i = 0; i < 3; i++) begin
      step(2'b00, 2'b00, 1'b0);
      chk("R5", "held", int'(port_gnt), 1);
    end
    step(2'b00, 2'b00, 1'b1);

    // R6/R8 walk, requests during it ignored
    step(2'b01, 2'b00, 1'b0);
    chk("R6", "code0", int'(sched_code), 0);
    step(2'b10, 2'b11, 1'b0);
    chk("R6", "code1", int'(sched_code), 3);
    chk("R8", "no grant in walk", int'(port_gnt), 0);
    step(2'b00, 2'b11, 1'b0);
    chk("R6", "code2", int'(sched_code), 1);
    step(2'b00, 2'b11, 1'b0);
    chk("R6", "code3", int'(sched_code), 2);
    step(2'b11, 2'b11, 1'b0);
    chk("R8", "walk not extended", int'(sched_busy), 0);
    chk("R7", "prio after walk", int'(prio), 1);
    chk("R8", "no grant at walk end", int'(port_gnt), 0);
    step(2'b00, 2'b11, 1'b0);
    chk("R3", "prio1 winner", int'(port_gnt), 2);
    step(2'b00, 2'b00, 1'b1);
    step(2'b00, 2'b01, 1'b0);
    chk("R2", "single at prio1", int'(port_gnt), 1);
    step(2'b00, 2'b00, 1'b1);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] sr, pr;
      logic ak;
      sr = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      pr = 2'($urandom_range(0, 3));
      ak = ($urandom_range(0, 9) < 3);
      step(sr, pr, ak);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule